// File: doc/BRIEF.md
# Loopback IQ Imbalance Trim Search Controller

This controller tunes the correction knobs of a transmit path while the transmitter is looped back into the receiver. The looped-back spectrum holds the unwanted image tone and a second, correlated mirror of it. Both tones fall together as the transmit imbalance shrinks, so one signal-strength number that holds their combined power is a valid cost. The controller lowers that single reading and does not try to separate the two tones.

Three knobs are searched one after another through a shared register write port. The first is an optional analog phase trim, which is tuned only when the block reports that it is present. The digital gain correction comes next, and the digital phase correction is last. Each knob gets a coarse-to-fine coordinate search. The step starts at a power of two and halves down to one LSB. After each probe write the controller waits a programmable settle time and then samples the strength input. A probe is kept only if it lowers the best reading seen so far. Probes that would leave the signed code range are skipped.

A start pulse launches a run. The block is busy while the run goes on, and a one-cycle done pulse closes it. The committed knob codes appear at the outputs during that done cycle. An abort returns the controller to idle and leaves the committed codes as they were.

Top module: `iq_trim_search`

## Requirements
- R1: A start pulse while idle raises busy on the next cycle. Busy stays high until the run ends. A start pulse while busy has no effect: the run continues and ends with exactly one done pulse.
- R2: Knob select codes are 0 for the analog phase trim, 1 for the digital gain and 2 for the digital phase. Within a run the knobs are tuned in that order, the select value of successive writes never decreases, and select value 3 is never driven.
- R3: When analog_present is low at start, no write with select 0 occurs during the run and the analog code output keeps its value.
- R4: The strength input is sampled on the clock edge that ends the cycle settle_cycles+1 cycles after the write cycle. Values present earlier have no effect on the result.
- R5: For each knob the first write is its current code, which sets the baseline reading. Probes follow at +2^k and then -2^k around the best code, for k = STEP_LOG down to 0. A probe replaces the best code only when its reading is strictly lower. For a reading that is V-shaped in each knob, with the target within 2^(STEP_LOG+1)-1 of the start code and inside the code range, the search ends at the target.
- R6: Codes are signed CODE_W-bit values. A probe whose code falls outside the signed range causes no write and no settle wait. A knob whose upward probes all fall out of range therefore takes exactly STEP_LOG+3 writes. A target beyond the range leaves the knob at the nearest reachable legal code.
- R7: Each knob ends with a write of its best code before the next knob starts.
- R8: done is a one-cycle pulse and busy is low during it. The three code outputs take the new values in the done cycle and change at no other time.
- R9: abort while busy drives busy low on the next cycle with no done pulse. No write occurs in the abort cycle, and the code outputs keep their values.
- R10: After reset, busy, done and wr_en are low and all three code outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| abort | input | 1 | Cancel the run in progress |
| analog_present | input | 1 | Analog phase trim exists; sampled at start |
| settle_cycles | input | CNT_W | Wait after each write before sampling |
| rssi | input | RSSI_W | Combined image plus mirror power reading, unsigned |
| wr_en | output | 1 | Knob register write strobe |
| wr_sel | output | 2 | Knob select: 0 analog phase, 1 gain, 2 digital phase |
| wr_data | output | CODE_W | Signed code being written |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ana_code | output | CODE_W | Committed analog phase trim code |
| gain_code | output | CODE_W | Committed digital gain code |
| phase_code | output | CODE_W | Committed digital phase code |

## Verification
Busy is due one cycle after the start pulse and falls one cycle after an abort. The bench samples both on the next falling edge after it drives the pulse. The strength reading is due settle_cycles+1 cycles after each write. The bench model returns a zero reading, which would win every comparison, until that many edges have passed since the last write it captured, so a design that samples early ends on a wrong code. The final codes are read on the falling edge inside the done cycle, and done must be low one cycle later. A monitor flags any code output change outside a done cycle.

// File: rtl/iq_trim_pkg.sv
`timescale 1ns/1ps
package iq_trim_pkg;

    localparam int N_KNOBS = 3;

    localparam logic [1:0] KNOB_ANA   = 2'd0;
    localparam logic [1:0] KNOB_GAIN  = 2'd1;
    localparam logic [1:0] KNOB_PHASE = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_SETTLE,
        S_NEXT,
        S_PICK,
        S_COMMIT,
        S_DONE
    } seq_state_e;

    // search cursor for one knob: baseline pending, and probe direction
    typedef struct packed {
        logic base;
        logic down;
    } cursor_t;

    function automatic logic [1:0] first_knob(input logic ana_present);
        return ana_present ? KNOB_ANA : KNOB_GAIN;
    endfunction

endpackage

// File: rtl/iq_trim_probe.sv
`timescale 1ns/1ps
module iq_trim_probe #(
    parameter int CODE_W = 6,
    parameter int SL_W   = 3
) (
    input  logic [CODE_W-1:0] center,
    input  logic [SL_W-1:0]   step_log,
    input  logic              down,
    output logic [CODE_W-1:0] cand,
    output logic              legal
);
    logic [CODE_W:0] ext;
    logic [CODE_W:0] stp;
    logic [CODE_W:0] sum;

    always_comb begin
        ext   = {center[CODE_W-1], center};
        stp   = {{CODE_W{1'b0}}, 1'b1} << step_log;
        sum   = down ? (ext - stp) : (ext + stp);
        cand  = sum[CODE_W-1:0];
        // one guard bit: the result fits when the top two bits agree
        legal = (sum[CODE_W] == sum[CODE_W-1]);
    end
endmodule

// File: rtl/iq_trim_settle.sv
`timescale 1ns/1ps
module iq_trim_settle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/iq_trim_bank.sv
`timescale 1ns/1ps
module iq_trim_bank #(
    parameter int CODE_W = 6,
    parameter int N      = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     open_run,
    input  logic                     upd_en,
    input  logic [1:0]               upd_idx,
    input  logic [CODE_W-1:0]        upd_val,
    input  logic                     commit,
    output logic [N-1:0][CODE_W-1:0] work_o,
    output logic [N-1:0][CODE_W-1:0] held_o
);
    for (genvar k = 0; k < N; k++) begin : g_knob
        always_ff @(posedge clk) begin
            if (rst) begin
                work_o[k] <= '0;
                held_o[k] <= '0;
            end else begin
                if (open_run) begin
                    work_o[k] <= held_o[k];
                end else if (upd_en && (upd_idx == 2'(k))) begin
                    work_o[k] <= upd_val;
                end
                if (commit) begin
                    held_o[k] <= work_o[k];
                end
            end
        end
    end
endmodule

// File: rtl/iq_trim_search.sv
`timescale 1ns/1ps
module iq_trim_search
    import iq_trim_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int RSSI_W   = 16,
    parameter int CNT_W    = 8,
    parameter int STEP_LOG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              analog_present,
    input  logic [CNT_W-1:0]  settle_cycles,
    input  logic [RSSI_W-1:0] rssi,
    output logic              wr_en,
    output logic [1:0]        wr_sel,
    output logic [CODE_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] ana_code,
    output logic [CODE_W-1:0] gain_code,
    output logic [CODE_W-1:0] phase_code
);
    localparam int SL_W = $clog2(STEP_LOG + 1);

    seq_state_e                           state;
    logic [1:0]                           knob;
    logic [SL_W-1:0]                      step_log;
    cursor_t                              cur;
    logic [RSSI_W-1:0]                    best;
    logic [CODE_W-1:0]                    probe;
    logic [N_KNOBS-1:0][CODE_W-1:0]       work;
    logic [N_KNOBS-1:0][CODE_W-1:0]       held;
    logic [CODE_W-1:0]                    cand;
    logic                                 legal;
    logic                                 expired;
    logic                                 quit;
    logic                                 better;
    logic                                 open_run;
    logic                                 upd_en;
    logic                                 commit;
    logic [1:0]                           knob_nxt;

    always_comb begin
        busy     = (state != S_IDLE) && (state != S_DONE);
        done     = (state == S_DONE);
        quit     = abort && busy;
        wr_en    = ((state == S_WRITE) || (state == S_COMMIT)) && !quit;
        wr_sel   = knob;
        wr_data  = (state == S_COMMIT) ? work[knob] : probe;
        open_run = (state == S_IDLE) && start;
        better   = !cur.base && (rssi < best);
        upd_en   = (state == S_SETTLE) && expired && better && !quit;
        commit   = (state == S_COMMIT) && (knob == KNOB_PHASE) && !quit;
        knob_nxt = knob + 2'd1;
    end

    iq_trim_probe #(.CODE_W(CODE_W), .SL_W(SL_W)) u_probe (
        .center  (work[knob]),
        .step_log(step_log),
        .down    (cur.down),
        .cand    (cand),
        .legal   (legal)
    );

    iq_trim_settle #(.CNT_W(CNT_W)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .load    (state == S_WRITE),
        .load_val(settle_cycles),
        .expired (expired)
    );

    iq_trim_bank #(.CODE_W(CODE_W), .N(N_KNOBS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .open_run(open_run),
        .upd_en  (upd_en),
        .upd_idx (knob),
        .upd_val (probe),
        .commit  (commit),
        .work_o  (work),
        .held_o  (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            knob     <= KNOB_ANA;
            step_log <= '0;
            cur      <= '0;
            best     <= '0;
            probe    <= '0;
        end else if (quit) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        knob     <= first_knob(analog_present);
                        cur.base <= 1'b1;
                        probe    <= held[first_knob(analog_present)];
                        state    <= S_WRITE;
                    end
                end
                S_WRITE: state <= S_SETTLE;
                S_SETTLE: begin
                    if (expired) begin
                        if (cur.base || better) best <= rssi;
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (cur.base) begin
                        cur.base <= 1'b0;
                        cur.down <= 1'b0;
                        step_log <= SL_W'(STEP_LOG);
                        state    <= S_PICK;
                    end else if (!cur.down) begin
                        cur.down <= 1'b1;
                        state    <= S_PICK;
                    end else if (step_log == '0) begin
                        state <= S_COMMIT;
                    end else begin
                        step_log <= step_log - 1'b1;
                        cur.down <= 1'b0;
                        state    <= S_PICK;
                    end
                end
                S_PICK: begin
                    if (legal) begin
                        probe <= cand;
                        state <= S_WRITE;
                    end else begin
                        state <= S_NEXT;
                    end
                end
                S_COMMIT: begin
                    if (knob == KNOB_PHASE) begin
                        state <= S_DONE;
                    end else begin
                        knob     <= knob_nxt;
                        cur.base <= 1'b1;
                        probe    <= work[knob_nxt];
                        state    <= S_WRITE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign ana_code   = held[KNOB_ANA];
    assign gain_code  = held[KNOB_GAIN];
    assign phase_code = held[KNOB_PHASE];
endmodule

// File: rtl/iq_trim_search_chk.sv
`timescale 1ns/1ps
module iq_trim_search_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              abort,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] ana_code,
    input logic [CODE_W-1:0] gain_code,
    input logic [CODE_W-1:0] phase_code
);
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_sel != 2'd3));

    a_r2_sel_order: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> !(wr_en && (wr_sel < $past(wr_sel))));

    a_r7_write_in_run: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_codes_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(ana_code) && $stable(gain_code) && $stable(phase_code)));

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (abort && busy) |=> (!busy && !done));

    a_r9_abort_no_write: assert property (@(posedge clk) disable iff (rst)
        (abort && busy) |-> !wr_en);
endmodule

bind iq_trim_search iq_trim_search_chk #(.CODE_W(CODE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .busy      (busy),
    .done      (done),
    .ana_code  (ana_code),
    .gain_code (gain_code),
    .phase_code(phase_code)
);

// File: tb/test_iq_trim_search.sv
`timescale 1ns/1ps
module test_iq_trim_search;
    localparam int CODE_W = 6;
    localparam int RSSI_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              abort = 1'b0;
    logic              analog_present = 1'b1;
    logic [CNT_W-1:0]  settle_cycles = '0;
    logic [RSSI_W-1:0] rssi;
    logic              wr_en;
    logic [1:0]        wr_sel;
    logic [CODE_W-1:0] wr_data;
    logic              busy, done;
    logic [CODE_W-1:0] ana_code, gain_code, phase_code;

    always #5 clk = ~clk;

    iq_trim_search #(.CODE_W(CODE_W), .RSSI_W(RSSI_W), .CNT_W(CNT_W), .STEP_LOG(4)) i_iq_trim_search (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .analog_present(analog_present), .settle_cycles(settle_cycles), .rssi(rssi),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy), .done(done),
        .ana_code(ana_code), .gain_code(gain_code), .phase_code(phase_code)
    );

    // ---------------- loopback model ----------------
    logic signed [CODE_W-1:0] knob_reg [3];
    int tgt_a, tgt_g, tgt_p;
    int age;
    int wr_tot [3];
    int done_tot, order_err, chg_err;
    logic [1:0] last_sel;
    logic [CODE_W-1:0] prev_a, prev_g, prev_p;

    function automatic int mag(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // image plus correlated mirror: both scale with each knob error
    always_comb begin
        if (age >= int'(settle_cycles))
            rssi = RSSI_W'(40 + 3 * mag(int'(knob_reg[0]) - tgt_a)
                              + 2 * mag(int'(knob_reg[1]) - tgt_g)
                              + mag(int'(knob_reg[2]) - tgt_p));
        else
            rssi = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 3; k++) knob_reg[k] <= '0;
            age      <= 255;
            last_sel <= 2'd0;
        end else begin
            if (start && !busy) last_sel <= 2'd0;
            if (wr_en) begin
                if (wr_sel < 2'd3) knob_reg[wr_sel] <= $signed(wr_data);
                age <= 0;
                if (wr_sel < 2'd3) wr_tot[wr_sel] <= wr_tot[wr_sel] + 1;
                if (wr_sel < last_sel) order_err <= order_err + 1;
                last_sel <= wr_sel;
            end else if (age < 255) begin
                age <= age + 1;
            end
            if (done) done_tot <= done_tot + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done &&
            (ana_code != prev_a || gain_code != prev_g || phase_code != prev_p))
            chg_err <= chg_err + 1;
        prev_a <= ana_code;
        prev_g <= gain_code;
        prev_p <= phase_code;
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sc(input logic [CODE_W-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic              ana;
        logic [7:0]        settle;
        logic signed [7:0] ta, tg, tp;
        logic signed [7:0] ea, eg, ep;
        logic [7:0]        wa, wp;
    } vec_t;

    // rows chain: each run starts from the codes the previous one committed
    localparam vec_t VEC [5] = '{
        '{1'b1, 8'd0, 8'sd5,   -8'sd9,  8'sd20,  8'sd5,   -8'sd9,  8'sd20,  8'd12, 8'd0},
        '{1'b1, 8'd5, -8'sd12, 8'sd3,   8'sd40,  -8'sd12, 8'sd3,   8'sd31,  8'd12, 8'd0},
        '{1'b1, 8'd1, -8'sd12, 8'sd3,   8'sd31,  -8'sd12, 8'sd3,   8'sd31,  8'd12, 8'd7},
        '{1'b0, 8'd2, 8'sd0,   -8'sd25, 8'sd7,   -8'sd12, -8'sd25, 8'sd7,   8'd0,  8'd0},
        '{1'b1, 8'd3, 8'sd18,  8'sd0,   -8'sd20, 8'sd18,  8'sd0,   -8'sd20, 8'd12, 8'd0}
    };

    initial begin
        bit seen;
        int w0, w2, d0, c0;
        for (int k = 0; k < 3; k++) wr_tot[k] = 0;
        done_tot = 0; order_err = 0; chg_err = 0;
        tgt_a = 0; tgt_g = 0; tgt_p = 0;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", int'(busy), 0);
        chk("R10 wr_en in reset", int'(wr_en), 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R10 done after reset", int'(done), 0);
        chk("R10 ana_code after reset", sc(ana_code), 0);
        chk("R10 gain_code after reset", sc(gain_code), 0);
        chk("R10 phase_code after reset", sc(phase_code), 0);

        // table of runs: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < 5; i++) begin
            analog_present = VEC[i].ana;
            settle_cycles  = VEC[i].settle;
            tgt_a = int'(VEC[i].ta);
            tgt_g = int'(VEC[i].tg);
            tgt_p = int'(VEC[i].tp);
            w0 = wr_tot[0]; w2 = wr_tot[2];
            pulse_start();
            chk("R1 busy one cycle after start", int'(busy), 1);
            wait_done(seen);
            chk("R8 done seen", int'(seen), 1);
            chk("R8 busy low in done cycle", int'(busy), 0);
            chk("R5 ana_code", sc(ana_code), int'(VEC[i].ea));
            chk("R5 gain_code", sc(gain_code), int'(VEC[i].eg));
            chk("R5 phase_code", sc(phase_code), int'(VEC[i].ep));
            chk("R3 analog writes", wr_tot[0] - w0, int'(VEC[i].wa));
            if (VEC[i].wp != 8'd0)
                chk("R6 phase writes with skipped probes", wr_tot[2] - w2, int'(VEC[i].wp));
            @(negedge clk);
            chk("R8 done lasts one cycle", int'(done), 0);
            chk("R2 write order", order_err, 0);
            chk("R7 final write restores best code", sc(knob_reg[2]), int'(VEC[i].ep));
        end

        // R1: second start while busy is ignored
        analog_present = 1'b1; settle_cycles = 8'd1;
        tgt_a = 2; tgt_g = -4; tgt_p = -1;
        d0 = done_tot;
        pulse_start();
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(seen);
        chk("R1 run completes despite extra start", int'(seen), 1);
        chk("R1 ana_code", sc(ana_code), 2);
        chk("R1 gain_code", sc(gain_code), -4);
        chk("R1 phase_code", sc(phase_code), -1);
        repeat (40) @(negedge clk);
        chk("R1 exactly one done", done_tot - d0, 1);
        chk("R1 idle after run", int'(busy), 0);

        // R9: abort mid-run
        tgt_a = 25; tgt_g = 25; tgt_p = 25;
        d0 = done_tot;
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R9 busy before abort", int'(busy), 1);
        abort = 1'b1;
        #1;
        chk("R9 no write in abort cycle", int'(wr_en), 0);
        @(negedge clk) abort = 1'b0;
        chk("R9 busy low after abort", int'(busy), 0);
        c0 = wr_tot[0] + wr_tot[1] + wr_tot[2];
        repeat (60) @(negedge clk);
        chk("R9 no done after abort", done_tot - d0, 0);
        chk("R9 no writes after abort", wr_tot[0] + wr_tot[1] + wr_tot[2] - c0, 0);
        chk("R9 ana_code kept", sc(ana_code), 2);
        chk("R9 gain_code kept", sc(gain_code), -4);
        chk("R9 phase_code kept", sc(phase_code), -1);

        // recovery run after abort
        pulse_start();
        wait_done(seen);
        chk("R5 ana_code after abort", sc(ana_code), 25);
        chk("R5 gain_code after abort", sc(gain_code), 25);
        chk("R5 phase_code after abort", sc(phase_code), 25);

        @(negedge clk);
        chk("R8 codes changed only in done cycles", chg_err, 0);
        chk("R2 order over all runs", order_err, 0);
        finish_run();
    end
endmodule